// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Dual-Channel Digital Potentiometer

This block is the serial command front end of a two-channel wiper controller. It watches the two-wire bus lines (SCL and SDA) with the system clock. Each line passes through a short synchronizer chain before any edge is detected. The block recognises START and STOP conditions and takes bytes MSB first. It answers only to a 7-bit address whose upper five bits are a build-time constant and whose lower two bits come from strap pins. The block never drives SDA high. It pulls the line low through `sda_oe`, and the pad turns that into an open-drain output.

A write transaction carries an instruction byte and then any number of data bytes. The instruction selects a channel and sets four control flags: midscale preset, shutdown and two general-purpose outputs. It is handed to the wiper core as a one-cycle strobe. Every data byte after it becomes a one-cycle code strobe for the selected channel. A read transaction has no instruction byte. The block returns the code of the channel that the most recent instruction selected, which the core supplies on `rd_code` for the channel shown on `rd_chan`.

The controller is one enumerated state machine:

| State | Role |
|-------|------|
| `ST_IDLE` | Waits for START. |
| `ST_ADDR` | Takes in the address byte. |
| `ST_ADDR_ACK` | Acknowledges the address. |
| `ST_INST` | Takes in the instruction byte. |
| `ST_INST_ACK` | Acknowledges the instruction. |
| `ST_DATA` | Takes in a data byte. |
| `ST_DATA_ACK` | Acknowledges a data byte. |
| `ST_RD_BYTE` | Shifts the returned code out. |
| `ST_RD_ACK` | Samples the master's acknowledge. |

Transitions:

- From every state, STOP goes to `ST_IDLE` and START goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address hit, or to `ST_IDLE` on a miss.
- `ST_ADDR_ACK` goes to `ST_INST` when the R/W bit is 0 and to `ST_RD_BYTE` when it is 1.
- `ST_INST` goes to `ST_INST_ACK`, and `ST_INST_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, and `ST_DATA_ACK` returns to `ST_DATA`.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on a master ACK, or to `ST_IDLE` on a NACK.

Every byte and acknowledge state moves on when a falling SCL edge completes its ninth bit.

Top module: `pot_i2c_slave`

## Requirements
- R1: The address byte is bits {0,1,0,1,1, addr_pins[1], addr_pins[0], R/W}, MSB first. Any other address byte gets no acknowledge and no strobe. After a miss the block ignores all bus traffic until the next START.
- R2: The last bit of the address byte selects the direction: 0 starts a write (instruction byte next) and 1 starts a read (returned code next).
- R3: The instruction byte is decoded from bit 7 down. Bit 7 is the channel, bit 6 is midscale, bit 5 is shutdown, bit 4 is out2 and bit 3 is out1. Bits 2..0 are ignored. These fields are presented on the cmd_* ports with a one-cycle `cmd_valid` pulse after the SCL falling edge that ends the instruction's acknowledge.
- R4: The block pulls SDA low (`sda_oe` = 1) during the ninth clock of the address, the instruction and every written data byte. It only changes SDA while SCL is low.
- R5: Each data byte produces a one-cycle `wr_valid` pulse after its acknowledge ends. The pulse carries the byte on `wr_code` and the instruction's channel on `wr_chan`. Further data bytes repeat this under the same instruction until STOP or START.
- R6: In a read, the returned code is driven MSB first immediately after the address acknowledge. It is the value of `rd_code` at that moment. A master ACK (SDA low on the ninth clock) sends the code again. A master NACK releases SDA and ends the transfer.
- R7: `rd_chan` shows the channel bit of the most recent instruction. After reset `rd_chan` is 0, `sda_oe` is 0 and no strobe is active.
- R8: A repeated START directly after an instruction, with no data byte and no STOP, still applies the instruction and begins a new address byte. This lets a channel be selected and then read back.
- R9: A write made of the address and the instruction only, ended by STOP, gives exactly one `cmd_valid` and no `wr_valid`.
- R10: A STOP at any point returns the block to idle with SDA released and discards a partly received byte. A START in the middle of a byte restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 2 | Strap pins giving the two low address bits |
| rd_code | input | 8 | Code of channel `rd_chan`, from the wiper core |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_chan | output | 1 | Channel selected by the latest instruction |
| cmd_valid | output | 1 | One-cycle instruction strobe |
| cmd_chan | output | 1 | Instruction channel select |
| cmd_midscale | output | 1 | Instruction midscale preset flag |
| cmd_shutdown | output | 1 | Instruction shutdown flag |
| cmd_out2 | output | 1 | Instruction value for general output 2 |
| cmd_out1 | output | 1 | Instruction value for general output 1 |
| wr_valid | output | 1 | One-cycle data byte strobe |
| wr_chan | output | 1 | Channel the data byte is meant for |
| wr_code | output | 8 | Data byte (wiper code) |

## Verification
The assertions assume that each SCL high and low phase lasts longer than the synchronizer delay plus one cycle. They also assume that the master moves SDA only while SCL is low, except when it forms a START or a STOP. Under those assumptions a START or STOP is seen as a single event, and the block's SDA changes land inside a low phase. The bench drives the bus with quarter-bit phases of ten system clocks, and it changes SDA only in the low phase or in the dedicated START and STOP tasks. It sweeps every combination of strap pins and address bits, all 32 instruction field patterns, and several code patterns per channel.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INST,
        ST_INST_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_e;

    typedef struct packed {
        logic chan;
        logic midscale;
        logic shutdown;
        logic out2;
        logic out1;
    } inst_fields_t;

endpackage

// File: rtl/pot_i2c_line_sync.sv
module pot_i2c_line_sync #(
    parameter int STAGES = 2      // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_rise =  synced[0] & ~prev[0];
    assign scl_fall = ~synced[0] &  prev[0];
    // SDA edges only count while SCL stays high across both samples
    assign start_ev = synced[0] & prev[0] &  prev[1] & ~synced[1];
    assign stop_ev  = synced[0] & prev[0] & ~prev[1] &  synced[1];

endmodule

// File: rtl/pot_i2c_byte_shift.sv
module pot_i2c_byte_shift
    import pot_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              cap_en,
    input  logic              shl_en,
    input  logic              cnt_en,
    input  logic              sda_bit,
    output logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (load) begin
            data  <= load_val;
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            if (cap_en)      data <= {data[BYTE_W-2:0], sda_bit};
            else if (shl_en) data <= {data[BYTE_W-2:0], 1'b0};
            if (cnt_en)      count <= count + 1'b1;
        end
    end

    // R4: a byte never runs past its ninth clock without a state change
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(BYTE_W));

endmodule

// File: rtl/pot_i2c_inst_decode.sv
module pot_i2c_inst_decode
    import pot_i2c_pkg::*;
(
    input  logic [4:0]   inst_hi,   // instruction byte bits 7..3
    output inst_fields_t fields
);
    always_comb begin
        fields.chan     = inst_hi[4];
        fields.midscale = inst_hi[3];
        fields.shutdown = inst_hi[2];
        fields.out2     = inst_hi[1];
        fields.out1     = inst_hi[0];
    end
endmodule

// File: rtl/pot_i2c_slave.sv
module pot_i2c_slave
    import pot_i2c_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b01011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_pins,
    input  logic [BYTE_W-1:0] rd_code,
    output logic              sda_oe,
    output logic              rd_chan,
    output logic              cmd_valid,
    output logic              cmd_chan,
    output logic              cmd_midscale,
    output logic              cmd_shutdown,
    output logic              cmd_out2,
    output logic              cmd_out1,
    output logic              wr_valid,
    output logic              wr_chan,
    output logic [BYTE_W-1:0] wr_code
);
    slv_state_e state, nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic sh_clear, sh_load, cap_en, shl_en, cnt_en;
    logic fire_cmd, fire_wr;
    logic [BYTE_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic byte_done, addr_hit;
    logic rw_q, m_ack_q, sel_chan;
    inst_fields_t fields;

    pot_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    pot_i2c_byte_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .load     (sh_load),
        .load_val (rd_code),
        .cap_en   (cap_en),
        .shl_en   (shl_en),
        .cnt_en   (cnt_en),
        .sda_bit  (sda_s),
        .data     (sr),
        .count    (cnt)
    );

    pot_i2c_inst_decode u_dec (
        .inst_hi (sr[BYTE_W-1:BYTE_W-5]),
        .fields  (fields)
    );

    assign byte_done = (cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (sr[BYTE_W-1:1] == {ADDR_HI, addr_pins});

    // next state and datapath controls
    always_comb begin
        nxt      = state;
        sh_clear = 1'b0;
        sh_load  = 1'b0;
        cap_en   = 1'b0;
        shl_en   = 1'b0;
        cnt_en   = 1'b0;
        fire_cmd = 1'b0;
        fire_wr  = 1'b0;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt      = ST_ADDR;
            sh_clear = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        cap_en = 1'b1;
                        cnt_en = 1'b1;
                    end else if (scl_fall && byte_done) begin
                        nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            nxt     = ST_RD_BYTE;
                            sh_load = 1'b1;
                        end else begin
                            nxt      = ST_INST;
                            sh_clear = 1'b1;
                        end
                    end
                end
                ST_INST: begin
                    if (scl_rise) begin
                        cap_en = 1'b1;
                        cnt_en = 1'b1;
                    end else if (scl_fall && byte_done) begin
                        nxt = ST_INST_ACK;
                    end
                end
                ST_INST_ACK: begin
                    if (scl_fall) begin
                        nxt      = ST_DATA;
                        sh_clear = 1'b1;
                        fire_cmd = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        cap_en = 1'b1;
                        cnt_en = 1'b1;
                    end else if (scl_fall && byte_done) begin
                        nxt = ST_DATA_ACK;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        nxt      = ST_DATA;
                        sh_clear = 1'b1;
                        fire_wr  = 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        cnt_en = 1'b1;
                    end else if (scl_fall) begin
                        if (byte_done) nxt    = ST_RD_ACK;
                        else           shl_en = 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        if (m_ack_q) begin
                            nxt     = ST_RD_BYTE;
                            sh_load = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            cmd_chan     <= 1'b0;
            cmd_midscale <= 1'b0;
            cmd_shutdown <= 1'b0;
            cmd_out2     <= 1'b0;
            cmd_out1     <= 1'b0;
            wr_valid     <= 1'b0;
            wr_chan      <= 1'b0;
            wr_code      <= '0;
            sel_chan     <= 1'b0;
            rw_q         <= 1'b0;
            m_ack_q      <= 1'b0;
        end else begin
            cmd_valid <= fire_cmd;
            wr_valid  <= fire_wr;
            if (fire_cmd) begin
                cmd_chan     <= fields.chan;
                cmd_midscale <= fields.midscale;
                cmd_shutdown <= fields.shutdown;
                cmd_out2     <= fields.out2;
                cmd_out1     <= fields.out1;
                sel_chan     <= fields.chan;
            end
            if (fire_wr) begin
                wr_code <= sr;
                wr_chan <= sel_chan;
            end
            if (state == ST_ADDR && nxt == ST_ADDR_ACK) rw_q <= sr[0];
            if (state == ST_RD_ACK && scl_rise)         m_ack_q <= ~sda_s;
        end
    end

    assign sda_oe = (state == ST_ADDR_ACK) || (state == ST_INST_ACK) ||
                    (state == ST_DATA_ACK) || (state == ST_RD_BYTE && !sr[BYTE_W-1]);
    assign rd_chan = sel_chan;

    // R3: instruction strobe lasts one cycle
    a_r3_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5: data strobe lasts one cycle
    a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R4: SDA is only pulled low inside an SCL low phase
    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R10: STOP returns to idle with SDA released
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

    // R10: START always restarts address reception
    a_r10_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

endmodule

// File: tb/pot_i2c_slave_test.sv
`timescale 1ns/1ps
module pot_i2c_slave_test;
    localparam time TCLK = 20ns;
    localparam time Q    = 200ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] pins = 2'b00;
    logic [7:0] rd_code;
    logic sda_oe, rd_chan, cmd_valid, cmd_chan, cmd_midscale, cmd_shutdown;
    logic cmd_out2, cmd_out1, wr_valid, wr_chan;
    logic [7:0] wr_code;
    wire sda_line = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cmd_cnt = 0;
    int wr_cnt = 0;
    logic [4:0] last_cmd = '0;
    logic last_wr_chan = 1'b0;
    logic [7:0] last_wr_code = '0;
    logic [7:0] core_mem [2];
    logic [7:0] exp_code [2];

    always #(TCLK/2) clk = ~clk;

    pot_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_pins(pins), .rd_code(rd_code), .sda_oe(sda_oe), .rd_chan(rd_chan),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_midscale(cmd_midscale),
        .cmd_shutdown(cmd_shutdown), .cmd_out2(cmd_out2), .cmd_out1(cmd_out1),
        .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_code(wr_code)
    );

    // simple model of the wiper core and strobe monitor
    assign rd_code = core_mem[rd_chan];
    always @(negedge clk) begin
        if (!rst_n) begin
            core_mem[0] <= 8'h80;
            core_mem[1] <= 8'h80;
        end else begin
            if (cmd_valid) begin
                cmd_cnt  <= cmd_cnt + 1;
                last_cmd <= {cmd_chan, cmd_midscale, cmd_shutdown, cmd_out2, cmd_out1};
                if (cmd_midscale) core_mem[cmd_chan] <= 8'h80;
            end
            if (wr_valid) begin
                wr_cnt       <= wr_cnt + 1;
                last_wr_chan <= wr_chan;
                last_wr_code <= wr_code;
                core_mem[wr_chan] <= wr_code;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; #Q; scl = 1'b1; #Q; ack = !sda_line; #Q; scl = 1'b0; #Q;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_line; #Q; scl = 1'b0; #Q;
        end
        sda_m = !give_ack; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] lo, input logic rw);
        return {5'b01011, lo, rw};
    endfunction

    // select a channel with an instruction, repeated START, read one byte
    task automatic readback(input logic ch, output logic [7:0] v);
        logic a;
        bus_start();
        wr_byte(addr_byte(pins, 1'b0), a);
        wr_byte({ch, 7'b0}, a);
        bus_start();
        wr_byte(addr_byte(pins, 1'b1), a);
        chk(a, "R2 read address ack", a, 1);
        rd_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin : watchdog
        #(TCLK * 190000);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic a;
        logic [7:0] v;
        int c0, w0;
        exp_code[0] = 8'h80;
        exp_code[1] = 8'h80;
        #5ns;
        #(TCLK * 5);
        rst_n = 1'b1;
        #(TCLK * 5);

        // R7: reset state
        chk(sda_oe == 1'b0, "R7 reset sda_oe", sda_oe, 0);
        chk(rd_chan == 1'b0, "R7 reset rd_chan", rd_chan, 0);
        chk(cmd_cnt == 0 && wr_cnt == 0, "R7 reset strobes", cmd_cnt + wr_cnt, 0);

        // R1/R4: sweep strap pins against address low bits
        for (int p = 0; p < 4; p++) begin
            pins = 2'(p);
            for (int q = 0; q < 4; q++) begin
                bus_start();
                wr_byte(addr_byte(2'(q), 1'b0), a);
                chk(a == (p == q), "R1 address match ack", a, int'(p == q));
                bus_stop();
            end
        end
        pins = 2'b01;
        bus_start();
        wr_byte({5'b01010, pins, 1'b0}, a);
        chk(!a, "R1 wrong fixed bits", a, 0);
        // R1: after a miss, a valid-looking address byte is ignored
        wr_byte(addr_byte(pins, 1'b0), a);
        chk(!a, "R1 idle until START", a, 0);
        wr_byte(8'hFF, a);
        bus_stop();
        chk(cmd_cnt == 0 && wr_cnt == 0, "R1 no strobes on miss", cmd_cnt + wr_cnt, 0);

        // R3/R9/R7: sweep of instruction fields, address+instruction+STOP
        for (int f = 0; f < 32; f++) begin
            c0 = cmd_cnt; w0 = wr_cnt;
            bus_start();
            wr_byte(addr_byte(pins, 1'b0), a);
            chk(a, "R4 address ack", a, 1);
            wr_byte({5'(f), 3'(f * 5)}, a);
            chk(a, "R4 instruction ack", a, 1);
            bus_stop();
            chk(cmd_cnt == c0 + 1, "R9 one instruction strobe", cmd_cnt - c0, 1);
            chk(wr_cnt == w0, "R9 no data strobe", wr_cnt - w0, 0);
            chk(last_cmd == 5'(f), "R3 instruction fields", last_cmd, f);
            chk(rd_chan == f[4], "R7 rd_chan follows instruction", rd_chan, f[4]);
            if (f[3]) exp_code[f[4]] = 8'h80;
        end

        // R5: repeated data bytes under one instruction
        for (int ch = 0; ch < 2; ch++) begin
            bus_start();
            wr_byte(addr_byte(pins, 1'b0), a);
            wr_byte({1'(ch), 7'b0}, a);
            for (int k = 0; k < 8; k++) begin
                v = 8'(k * 37 + ch * 91 + 5);
                w0 = wr_cnt;
                wr_byte(v, a);
                chk(a, "R4 data ack", a, 1);
                chk(wr_cnt == w0 + 1, "R5 one data strobe", wr_cnt - w0, 1);
                chk(last_wr_code == v, "R5 data code", last_wr_code, v);
                chk(last_wr_chan == 1'(ch), "R5 data channel", last_wr_chan, ch);
                exp_code[ch] = v;
            end
            bus_stop();
        end

        // R6/R8: select channel, repeated START, read with ACK then NACK
        for (int ch = 0; ch < 2; ch++) begin
            w0 = wr_cnt; c0 = cmd_cnt;
            bus_start();
            wr_byte(addr_byte(pins, 1'b0), a);
            wr_byte({1'(ch), 7'b0}, a);
            bus_start();
            wr_byte(addr_byte(pins, 1'b1), a);
            chk(a, "R2 read address ack", a, 1);
            chk(cmd_cnt == c0 + 1 && wr_cnt == w0, "R8 instruction applied, no data",
                cmd_cnt - c0, 1);
            chk(rd_chan == 1'(ch), "R8 channel selected", rd_chan, ch);
            rd_byte(1'b1, v);
            chk(v == exp_code[ch], "R6 first read byte", v, exp_code[ch]);
            rd_byte(1'b0, v);
            chk(v == exp_code[ch], "R6 read after master ACK", v, exp_code[ch]);
            #Q;
            chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
            bus_stop();
        end

        // R2: read with no preceding instruction returns last channel
        bus_start();
        wr_byte(addr_byte(pins, 1'b1), a);
        chk(a, "R2 read address ack", a, 1);
        rd_byte(1'b0, v);
        bus_stop();
        chk(v == exp_code[1], "R2 read of selected channel", v, exp_code[1]);

        // R10: STOP inside a data byte discards it
        w0 = wr_cnt;
        bus_start();
        wr_byte(addr_byte(pins, 1'b0), a);
        wr_byte(8'h00, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        #Q;
        chk(sda_oe == 1'b0, "R10 released after STOP", sda_oe, 0);
        chk(wr_cnt == w0, "R10 partial byte dropped", wr_cnt - w0, 0);
        readback(1'b0, v);
        chk(v == exp_code[0], "R10 code unchanged", v, exp_code[0]);

        // R10: START inside a data byte restarts address reception
        w0 = wr_cnt;
        bus_start();
        wr_byte(addr_byte(pins, 1'b0), a);
        wr_byte(8'h00, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        wr_byte(addr_byte(pins, 1'b0), a);
        chk(a, "R10 address after mid-byte START", a, 1);
        wr_byte(8'h80, a);
        wr_byte(8'h3C, a);
        bus_stop();
        chk(wr_cnt == w0 + 1, "R10 only full byte written", wr_cnt - w0, 1);
        chk(last_wr_code == 8'h3C && last_wr_chan == 1'b1, "R10 restarted write",
            last_wr_code, 8'h3C);
        exp_code[1] = 8'h3C;
        readback(1'b1, v);
        chk(v == exp_code[1], "R6 readback after restart", v, exp_code[1]);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule